// File: doc/BRIEF.md
# Byte-Indexed Table Lookup Unit

This block assembles a 32-bit word one byte at a time from a small lookup table. The table holds up to four 64-bit entries, 32 bytes in all, presented as one packed 256-bit vector. An index word carries four 8-bit indices, one for each byte lane of the result. Each lane works on its own: if its index lies inside the active table length, it fetches that table byte. If not, it passes through the byte in the same position of a default word.

A 2-bit length select sets how many entries are live. The byte bound is eight times the select value plus one, so the bound is 8, 16, 24 or 32 bytes. Inputs are sampled on a start strobe. The assembled word is registered and announced by a one-cycle valid pulse in the following cycle, and it stays on the output until the next start.

Top module: `byte_table_lookup`

## Requirements
- R1: While reset is asserted (`rst_n` low) and after reset until the first start, `result` is 0 and `result_vld` is low.
- R2: `result_vld` is high in exactly the cycle after a cycle with `start` high, and low otherwise.
- R3: A lane whose index v is in range outputs table byte v. Byte v sits at `table_bits[8v+7:8v]`, which is byte v[2:0] of entry v[4:3], where entry e is `table_bits[64e+63:64e]`.
- R4: A lane whose index is out of range outputs the same-position byte of `dflt_word` unchanged.
- R5: An index v is in range only when v < 8*(`len_sel`+1), where `len_sel` = 0, 1, 2, 3 gives bounds of 8, 16, 24, 32.
- R6: Index values from 32 to 255 always select the default byte, whatever the value of `len_sel`.
- R7: Lane k (k = 0..3) uses `idx_word[8k+7:8k]` and writes `result[8k+7:8k]`. Its choice does not depend on the other lanes.
- R8: While `start` is low, `result` holds its value regardless of changes on the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Sample strobe for all data inputs |
| idx_word | input | 32 | Four 8-bit lane indices |
| dflt_word | input | 32 | Fallback bytes for out-of-range lanes |
| table_bits | input | 256 | Packed table; byte i at bits [8i+7:8i] |
| len_sel | input | 2 | Live entries minus one |
| result | output | 32 | Registered assembled word |
| result_vld | output | 1 | One-cycle pulse when a new result is present |

## Verification
The bench sweeps every index value 0 to 255 through every lane under all four length settings, so the boundary indices 7/8, 15/16, 23/24, 31/32 and 255 are all covered. A design with an off-by-one bound would fetch a table byte where the default byte is expected, or the other way round. A design that reduces large indices modulo the table size would return table data for indices of 32 and above. A design with a mixed-up entry or byte selection, or with crossed lanes, would place a wrong byte that the per-lane expected value exposes. Between samples the inputs are changed while start is low, so a design that loaded the result on every cycle would show the new data, and a valid that lingered past one cycle would be caught.

// File: rtl/byte_table_lookup.sv
module byte_table_lookup #(
  parameter int LANES       = 4,
  parameter int LANE_W      = 8,
  parameter int ENTRIES     = 4,
  parameter int ENTRY_BYTES = 8
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    start,
  input  logic [LANES*LANE_W-1:0]                 idx_word,
  input  logic [LANES*LANE_W-1:0]                 dflt_word,
  input  logic [ENTRIES*ENTRY_BYTES*LANE_W-1:0]   table_bits,
  input  logic [(ENTRIES>1?$clog2(ENTRIES):1)-1:0] len_sel,
  output logic [LANES*LANE_W-1:0]                 result,
  output logic                                    result_vld
);
  localparam int OUT_W   = LANES*LANE_W;
  localparam int ENT_W   = ENTRY_BYTES*LANE_W;
  localparam int TBL_W   = ENTRIES*ENT_W;
  localparam int TBL_B   = ENTRIES*ENTRY_BYTES;
  localparam int SEL_W   = ENTRIES > 1 ? $clog2(ENTRIES) : 1;
  localparam int BSEL_W  = $clog2(ENTRY_BYTES);
  localparam int BW      = LANE_W + 1;

  logic [ENT_W-1:0] ent [ENTRIES];
  logic [BW-1:0]    bound;
  logic [OUT_W-1:0] nxt;

  assign bound = (BW'(len_sel) + BW'(1)) * BW'(ENTRY_BYTES);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign ent[e] = table_bits[e*ENT_W +: ENT_W];
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] ix;
    logic [SEL_W-1:0]  esel;
    logic [BSEL_W-1:0] bsel;
    logic              in_rng;
    logic [LANE_W-1:0] tbyte;

    assign ix     = idx_word[k*LANE_W +: LANE_W];
    assign esel   = ix[BSEL_W +: SEL_W];
    assign bsel   = ix[BSEL_W-1:0];
    assign in_rng = ({1'b0, ix} < bound) && ({1'b0, ix} < BW'(TBL_B));
    assign tbyte  = ent[esel][int'(bsel)*LANE_W +: LANE_W];
    assign nxt[k*LANE_W +: LANE_W] = in_rng ? tbyte : dflt_word[k*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      result_vld <= 1'b0;
    end else begin
      result_vld <= start;
      if (start) result <= nxt;
    end
  end
endmodule

module byte_table_lookup_chk #(
  parameter int OUT_W = 32,
  parameter int TBL_W = 256,
  parameter int LS_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [OUT_W-1:0] idx_word,
  input logic [OUT_W-1:0] dflt_word,
  input logic [TBL_W-1:0] table_bits,
  input logic [LS_W-1:0]  len_sel,
  input logic [OUT_W-1:0] result,
  input logic             result_vld
);
  always @(posedge clk)
    if (!rst_n) assert_reset_state_R1: assert (result == '0 && !result_vld);

  assert_vld_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> result_vld);

  assert_vld_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !result_vld);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(result));

  assert_first_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idx_word[7:0] < 8'd8) |=>
      result[7:0] == $past(table_bits[int'(idx_word[2:0])*8 +: 8]));

  assert_short_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len_sel == '0 && idx_word[15:8] >= 8'd8) |=>
      result[15:8] == $past(dflt_word[15:8]));

  assert_wide_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idx_word[31:24] >= 8'd32) |=>
      result[31:24] == $past(dflt_word[31:24]));
endmodule

bind byte_table_lookup byte_table_lookup_chk #(
  .OUT_W(OUT_W), .TBL_W(TBL_W), .LS_W(SEL_W)
) u_chk (.*);

// File: tb/byte_table_lookup_test.sv
module byte_table_lookup_test;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  idx_word = '0;
  logic [31:0]  dflt_word = '0;
  logic [255:0] table_bits = '0;
  logic [1:0]   len_sel = '0;
  logic [31:0]  result;
  logic         result_vld;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  byte_table_lookup uut (
    .clk(clk), .rst_n(rst_n), .start(start), .idx_word(idx_word),
    .dflt_word(dflt_word), .table_bits(table_bits), .len_sel(len_sel),
    .result(result), .result_vld(result_vld)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] iw, input logic [31:0] dw,
                                        input logic [255:0] tb, input logic [1:0] ls);
    logic [31:0] r;
    int lim;
    lim = 8 * (int'(ls) + 1);
    for (int k = 0; k < 4; k++) begin
      int v;
      v = int'(iw[8*k +: 8]);
      if (v < lim) r[8*k +: 8] = tb[8*v +: 8];
      else         r[8*k +: 8] = dw[8*k +: 8];
    end
    return r;
  endfunction

  initial begin
    #(PERIOD*200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp;
    for (int i = 0; i < 32; i++) table_bits[8*i +: 8] = 8'(i*53 + 17);
    repeat (3) @(negedge clk);
    check("R1 reset result", result, 32'h0);
    check("R1 reset valid", {31'b0, result_vld}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {result[30:0], result_vld}, 32'h0);

    for (int ls = 0; ls < 4; ls++) begin
      for (int i = 0; i < 32; i++) table_bits[8*i +: 8] = 8'(i*53 + 17 + ls*91);
      for (int v = 0; v < 256; v++) begin
        len_sel   = 2'(ls);
        idx_word  = {8'(255 - v), 8'(v + 7), 8'(v ^ 8'h15), 8'(v)};
        dflt_word = {8'(v*3), 8'(v + 1), ~8'(v), 8'(v ^ 8'hA5)};
        start     = 1'b1;
        exp       = model(idx_word, dflt_word, table_bits, len_sel);
        @(negedge clk);
        start = 1'b0;
        check("R2 valid after start", {31'b0, result_vld}, 32'h1);
        check("R3 R4 R5 R6 R7 lane bytes", result, exp);
        idx_word  = ~idx_word;
        dflt_word = ~dflt_word;
        table_bits = ~table_bits;
        @(negedge clk);
        table_bits = ~table_bits;
        check("R2 single pulse", {31'b0, result_vld}, 32'h0);
        check("R8 hold without start", result, exp);
      end
    end

    len_sel = 2'd3;
    idx_word = 32'h1F_20_00_FF;
    dflt_word = 32'hDEADBEEF;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R6 index 32 and 255 default, R3 ends",
          result, {table_bits[8*31 +: 8], 8'hAD, table_bits[7:0], 8'hEF});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule